// File: doc/BRIEF.md
# Register Window Occupancy Tracker

This block keeps the bookkeeping for a windowed register file. Four small counters hold how many windows may still be pushed by a call (free-save), how many may be popped by a return (free-restore), how many belong to another context (foreign), and how many are known to be clean (clean). A window index shows which window is active. A six-bit trap-selector register chooses among trap handlers. A core issues one operation per cycle: push, pop, flush check, spill-complete or fill-complete. It can also load the pointer or the foreign counter. For each operation the block either moves its counters and index, or it raises a trap of nine-bit type one cycle later.

A spill or fill trap type is built from a base code and the trap-selector register. When foreign windows exist, the upper three selector bits go into the trap type and a marker bit is set. When none exist, the lower three selector bits are used. The pointer seen by software counts in the opposite direction to the internal index.

Top module: `regwin_tracker`

## Requirements
- R1: After reset, free-save reads NWIN-2, clean reads NWIN-1, free-restore and foreign read 0, ptr_rd reads NWIN-1 (internal index 0), trap_valid is 0.
- R2: A push (op 1) with free-save nonzero and clean not equal to free-restore lowers free-save by 1, raises free-restore by 1, and raises ptr_rd by 1 modulo NWIN, with no trap.
- R3: A push with free-save equal to 0 raises a spill trap (base 9'h080) and leaves every counter and the pointer unchanged. This check takes priority over R4.
- R4: A push with free-save nonzero and clean equal to free-restore raises trap type 9'h024 and changes no state.
- R5: A pop (op 2) with free-restore nonzero raises free-save by 1, lowers free-restore by 1, and lowers ptr_rd by 1 modulo NWIN.
- R6: A pop with free-restore equal to 0 raises a fill trap (base 9'h0C0) and changes no state.
- R7: The low bits of a spill or fill type are set as follows. If foreign is nonzero, bit 5 is set and selector bits 5:3 go to type bits 4:2. Otherwise selector bits 2:0 go to type bits 4:2. The selector used is the value held before any write in the same cycle.
- R8: A flush check (op 3) raises a spill trap unless free-save equals NWIN-2. It never changes state.
- R9: A spill-complete (op 4) raises free-save by 1. It then lowers foreign by 1 if foreign is nonzero; otherwise it lowers free-restore by 1.
- R10: A fill-complete (op 5) raises free-restore by 1. It raises clean by 1 only while clean is below NWIN-1. It then lowers foreign by 1 if foreign is nonzero; otherwise it lowers free-save by 1.
- R11: A pointer load (op 6) of value v makes ptr_rd read v modulo NWIN.
- R12: trap_valid is high for exactly the one cycle after a trapping operation and low after any other operation, including op 0 (no operation). Counters wrap modulo 2^CW.
- R13: A foreign load (op 7) sets foreign to the low CW bits of wr_data. A selector write (wsel_we) takes effect for operations in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| op | input | 3 | operation code |
| wr_data | input | PTR_IN_W | value for pointer or foreign load |
| wsel_we | input | 1 | trap-selector write enable |
| wsel_in | input | 6 | trap-selector write value |
| ptr_rd | output | CW | software-numbered window pointer |
| free_save | output | CW | free-save counter |
| free_restore | output | CW | free-restore counter |
| foreign | output | CW | foreign-window counter |
| clean | output | CW | clean-window counter |
| trap_valid | output | 1 | trap pulse |
| trap_type | output | 9 | trap type |

## Verification
The bench builds the block with NWIN=6. That count is not a power of two, so the pointer wraps at 5→0 instead of at a width boundary. Loaded pointer values of 6 and above must be reduced by a true modulo, and the counters still wrap at 8. The flush and clean-cap limits (4 and 5) are also reached within a few operations. Random foreign loads and selector writes drive both branches of the trap-type composition.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_PUSH     = 3'd1,
    OP_POP      = 3'd2,
    OP_FLUSH    = 3'd3,
    OP_SPILLED  = 3'd4,
    OP_FILLED   = 3'd5,
    OP_LD_PTR   = 3'd6,
    OP_LD_FRGN  = 3'd7
  } wop_e;
endpackage

// File: rtl/regwin_trapenc.sv
module regwin_trapenc #(
  parameter logic [8:0] MARK = 9'h020
) (
  input  logic [8:0] base,
  input  logic       frgn_nz,
  input  logic [5:0] wsel,
  output logic [8:0] ttype
);
  always_comb begin
    if (frgn_nz) ttype = base | MARK | {4'b0, wsel[5:3], 2'b00};
    else         ttype = base | {4'b0, wsel[2:0], 2'b00};
  end
endmodule

// File: rtl/regwin_ptr.sv
module regwin_ptr #(
  parameter int NWIN     = 8,
  parameter int PTR_IN_W = 8,
  localparam int IW      = $clog2(NWIN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_dn,
  input  logic                step_up,
  input  logic                load,
  input  logic [PTR_IN_W-1:0] load_val,
  output logic [IW-1:0]       arch
);
  localparam logic [IW-1:0]       LAST  = IW'(NWIN - 1);
  localparam logic [PTR_IN_W-1:0] NW_IN = PTR_IN_W'(NWIN);

  logic [IW-1:0]       idx_q, idx_n;
  logic [PTR_IN_W-1:0] red;
  logic                en;

  assign red = load_val % NW_IN;
  assign en  = step_dn | step_up | load;

  always_comb begin
    idx_n = idx_q;
    if (load)         idx_n = LAST - IW'(red);
    else if (step_dn) idx_n = (idx_q == '0) ? LAST : idx_q - 1'b1;
    else if (step_up) idx_n = (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  idx_q <= '0;
    else if (en) idx_q <= idx_n;
  end

  assign arch = LAST - idx_q;

  p_idx_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST);
  p_push_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && !load) |=> arch == (($past(arch) == LAST) ? '0 : $past(arch) + 1'b1));
endmodule

// File: rtl/regwin_tracker.sv
module regwin_tracker
  import regwin_pkg::*;
#(
  parameter int         NWIN       = 8,
  parameter int         PTR_IN_W   = 8,
  parameter logic [8:0] SPILL_BASE = 9'h080,
  parameter logic [8:0] FILL_BASE  = 9'h0C0,
  parameter logic [8:0] CLEAN_CODE = 9'h024,
  parameter logic [8:0] MARK       = 9'h020,
  localparam int        CW         = $clog2(NWIN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          op,
  input  logic [PTR_IN_W-1:0] wr_data,
  input  logic                wsel_we,
  input  logic [5:0]          wsel_in,
  output logic [CW-1:0]       ptr_rd,
  output logic [CW-1:0]       free_save,
  output logic [CW-1:0]       free_restore,
  output logic [CW-1:0]       foreign,
  output logic [CW-1:0]       clean,
  output logic                trap_valid,
  output logic [8:0]          trap_type
);
  localparam logic [CW-1:0] FULL_SAVE = CW'(NWIN - 2);
  localparam logic [CW-1:0] MAX_CLEAN = CW'(NWIN - 1);

  wop_e          opc;
  logic [CW-1:0] cs_q, cr_q, ow_q, cl_q;
  logic [CW-1:0] cs_n, cr_n, ow_n, cl_n;
  logic [5:0]    ws_q;
  logic          tv_q, tv_n;
  logic [8:0]    tt_q, tt_n;
  logic          sel_fill, step_dn, step_up, load_ptr, cnt_en;
  logic [8:0]    enc_type;
  logic          ow_nz;

  assign opc   = wop_e'(op);
  assign ow_nz = (ow_q != '0);

  regwin_trapenc #(.MARK(MARK)) u_enc (
    .base    (sel_fill ? FILL_BASE : SPILL_BASE),
    .frgn_nz (ow_nz),
    .wsel    (ws_q),
    .ttype   (enc_type)
  );

  regwin_ptr #(.NWIN(NWIN), .PTR_IN_W(PTR_IN_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_dn  (step_dn),
    .step_up  (step_up),
    .load     (load_ptr),
    .load_val (wr_data),
    .arch     (ptr_rd)
  );

  always_comb begin
    cs_n = cs_q; cr_n = cr_q; ow_n = ow_q; cl_n = cl_q;
    tv_n = 1'b0; tt_n = tt_q;
    sel_fill = 1'b0; step_dn = 1'b0; step_up = 1'b0; load_ptr = 1'b0;
    case (opc)
      OP_PUSH: begin
        if (cs_q == '0) begin
          tv_n = 1'b1; tt_n = enc_type;
        end else if (cl_q == cr_q) begin
          tv_n = 1'b1; tt_n = CLEAN_CODE;
        end else begin
          cs_n = cs_q - 1'b1; cr_n = cr_q + 1'b1; step_dn = 1'b1;
        end
      end
      OP_POP: begin
        sel_fill = 1'b1;
        if (cr_q == '0) begin
          tv_n = 1'b1; tt_n = enc_type;
        end else begin
          cs_n = cs_q + 1'b1; cr_n = cr_q - 1'b1; step_up = 1'b1;
        end
      end
      OP_FLUSH: begin
        if (cs_q != FULL_SAVE) begin
          tv_n = 1'b1; tt_n = enc_type;
        end
      end
      OP_SPILLED: begin
        cs_n = cs_q + 1'b1;
        if (ow_nz) ow_n = ow_q - 1'b1;
        else       cr_n = cr_q - 1'b1;
      end
      OP_FILLED: begin
        cr_n = cr_q + 1'b1;
        if (cl_q < MAX_CLEAN) cl_n = cl_q + 1'b1;
        if (ow_nz) ow_n = ow_q - 1'b1;
        else       cs_n = cs_q - 1'b1;
      end
      OP_LD_PTR:  load_ptr = 1'b1;
      OP_LD_FRGN: ow_n = wr_data[CW-1:0];
      default: ;
    endcase
  end

  assign cnt_en = (opc != OP_NOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= FULL_SAVE; cr_q <= '0; ow_q <= '0; cl_q <= MAX_CLEAN;
    end else if (cnt_en) begin
      cs_q <= cs_n; cr_q <= cr_n; ow_q <= ow_n; cl_q <= cl_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ws_q <= '0;
    else if (wsel_we) ws_q <= wsel_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tv_q <= 1'b0; tt_q <= '0;
    end else begin
      tv_q <= tv_n;
      if (tv_n) tt_q <= tt_n;
    end
  end

  assign free_save    = cs_q;
  assign free_restore = cr_q;
  assign foreign      = ow_q;
  assign clean        = cl_q;
  assign trap_valid   = tv_q;
  assign trap_type    = tt_q;

  p_spill_on_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd1 && free_save == '0) |=> trap_valid && $stable(free_restore));
  p_fill_on_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd2 && free_restore == '0) |=> trap_valid && $stable(free_save));
  p_nop_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd0) |=> !trap_valid);
  p_clean_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clean <= MAX_CLEAN);
  p_spilled_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd4) |=> free_save == CW'($past(free_save) + 1'b1));
  p_flush_still_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd3) |=> $stable(free_save) && $stable(free_restore) && $stable(ptr_rd));
endmodule

// File: tb/regwin_tracker_test.sv
module regwin_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 6;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    op = 3'd0;
  logic [7:0]    wr_data = 8'd0;
  logic          wsel_we = 1'b0;
  logic [5:0]    wsel_in = 6'd0;
  logic [CW-1:0] ptr_rd, free_save, free_restore, foreign, clean;
  logic          trap_valid;
  logic [8:0]    trap_type;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int  e_cs, e_cr, e_ow, e_cl, e_ptr, e_ws;
  bit  e_tv;
  int  e_tt;
  string tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  regwin_tracker #(.NWIN(NW), .PTR_IN_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .op(op), .wr_data(wr_data),
    .wsel_we(wsel_we), .wsel_in(wsel_in), .ptr_rd(ptr_rd),
    .free_save(free_save), .free_restore(free_restore), .foreign(foreign),
    .clean(clean), .trap_valid(trap_valid), .trap_type(trap_type)
  );

  function automatic int enc(int base, int ow, int ws);
    if (ow != 0) return base | 'h20 | (((ws >> 3) & 7) << 2);
    return base | ((ws & 7) << 2);
  endfunction

  task automatic chk(string t, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic check_all();
    chk({tag, " free_save"}, free_save, e_cs);
    chk({tag, " free_restore"}, free_restore, e_cr);
    chk({tag, " foreign"}, foreign, e_ow);
    chk({tag, " clean"}, clean, e_cl);
    chk({tag, " ptr_rd"}, ptr_rd, e_ptr);
    chk("R12 trap_valid", trap_valid, e_tv);
    if (e_tv) chk({"R7 trap_type ", tag}, trap_type, e_tt);
  endtask

  task automatic apply(int o, int d, bit we, int ws);
    op = 3'(o); wr_data = 8'(d); wsel_we = we; wsel_in = 6'(ws);
    e_tv = 1'b0; tag = "R12";
    case (o)
      1: if (e_cs == 0) begin e_tv = 1; e_tt = enc('h080, e_ow, e_ws); tag = "R3"; end
         else if (e_cl == e_cr) begin e_tv = 1; e_tt = 'h024; tag = "R4"; end
         else begin e_cs = (e_cs + 7) % 8; e_cr = (e_cr + 1) % 8; e_ptr = (e_ptr + 1) % NW; tag = "R2"; end
      2: if (e_cr == 0) begin e_tv = 1; e_tt = enc('h0C0, e_ow, e_ws); tag = "R6"; end
         else begin e_cs = (e_cs + 1) % 8; e_cr = (e_cr + 7) % 8; e_ptr = (e_ptr + NW - 1) % NW; tag = "R5"; end
      3: begin tag = "R8"; if (e_cs != NW - 2) begin e_tv = 1; e_tt = enc('h080, e_ow, e_ws); end end
      4: begin tag = "R9"; e_cs = (e_cs + 1) % 8;
           if (e_ow != 0) e_ow = e_ow - 1; else e_cr = (e_cr + 7) % 8; end
      5: begin tag = "R10"; e_cr = (e_cr + 1) % 8; if (e_cl < NW - 1) e_cl++;
           if (e_ow != 0) e_ow = e_ow - 1; else e_cs = (e_cs + 7) % 8; end
      6: begin tag = "R11"; e_ptr = (d & 255) % NW; end
      7: begin tag = "R13"; e_ow = d & 7; end
      default: ;
    endcase
    if (we) e_ws = ws & 63;
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++; n_run++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, 100000);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    e_cs = NW - 2; e_cr = 0; e_ow = 0; e_cl = NW - 1; e_ptr = NW - 1; e_ws = 0;
    e_tv = 0; e_tt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1";
    check_all();
    // R4: clean == free_restore impossible at reset (5 vs 0); push until cs==0 -> R3
    for (int i = 0; i < 5; i++) apply(1, 0, 0, 0);
    apply(3, 0, 1, 6'b101_011);     // R8 flush traps, selector written same cycle
    apply(1, 0, 0, 0);              // R3 spill with new selector, foreign 0 (R7)
    apply(7, 2, 0, 0);              // R13 foreign load
    apply(1, 0, 0, 0);              // R7 marker branch
    for (int i = 0; i < 6; i++) apply(2, 0, 0, 0);  // R5 pops, then R6 fill
    apply(6, 200, 0, 0);            // R11 pointer load 200 mod 6
    apply(6, 5, 0, 0);
    for (int i = 0; i < 4; i++) apply(5, 0, 0, 0);  // R10 fill-complete, clean capped
    for (int i = 0; i < 4; i++) apply(4, 0, 0, 0);  // R9 spill-complete
    apply(0, 0, 0, 0);              // R12 nop
    // R4: make clean equal free_restore
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    e_cs = NW - 2; e_cr = 0; e_ow = 0; e_cl = NW - 1; e_ptr = NW - 1; e_ws = 0;
    @(negedge clk);
    tag = "R1"; e_tv = 0; check_all();
    apply(7, 0, 0, 0);
    for (int i = 0; i < 4; i++) apply(1, 0, 0, 0);
    apply(4, 0, 0, 0); apply(4, 0, 0, 0);
    apply(1, 0, 0, 0); apply(1, 0, 0, 0);
    apply(5, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      int o;
      if (r < 25) o = 1; else if (r < 50) o = 2; else if (r < 58) o = 3;
      else if (r < 68) o = 4; else if (r < 78) o = 5; else if (r < 84) o = 6;
      else if (r < 90) o = 7; else o = 0;
      apply(o, $urandom_range(0, 255), ($urandom_range(0, 3) == 0), $urandom_range(0, 63));
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule